// File: doc/BRIEF.md
# H-Bridge Dead-Time PWM Driver

This block produces the four gate-drive waveforms for a full bridge built from two buck-converter legs that feed a thermoelectric cooler. One free-running period counter is shared by both legs. A leg that is switching alternates between high-side conduction and low-side conduction, with a dead interval at each hand-over. The leg that is not switching holds its output node at ground. The high-side switches are P-channel, so their gate signals are active low. The low-side switches are N-channel, so their gate signals are active high.

A controller supplies four values: a drive selection (side A switching, side B switching, or both legs off), a high-side conduction time, a dead-time length and a period length, all counted in clock cycles. The block samples these values only as the counter wraps, so every period is built from a single consistent setting and no truncated pulse can appear. Values that cannot be realised are clamped before use. The dead time is limited to half the period. The conduction time is limited so that it plus two dead times fits inside the period. The period has a floor of four cycles.

Top module: `hbridge_pwm_drv`

## Requirements
- R1: While reset is asserted, and after reset until the first applied setting takes effect, both high-side gate outputs are 1 (switch off) and both low-side gate outputs are 0 (switch off).
- R2: With drive selection 2'b01 (side A switching), `pwm_ah_o` is 0 for exactly the high-side on-time cycles of each period and `pwm_al_o` is 1 for exactly period − on-time − 2 × dead-time cycles. Side B is held grounded: `pwm_bh_o` = 1 and `pwm_bl_o` = 1.
- R3: With drive selection 2'b10 (side B switching), `pwm_bh_o` and `pwm_bl_o` follow the same timing as R2, and side A is held grounded: `pwm_ah_o` = 1 and `pwm_al_o` = 1.
- R4: With drive selection 2'b00 or 2'b11, both legs are off: `pwm_ah_o` = `pwm_bh_o` = 1 and `pwm_al_o` = `pwm_bl_o` = 0.
- R5: On the switching leg, no cycle has the high-side switch on (gate 0) together with the low-side switch on (gate 1). Each period has exactly 2 × dead-time cycles in which both switches of that leg are off.
- R6: An on-time larger than period − 2 × dead-time is treated as period − 2 × dead-time.
- R7: A dead-time larger than floor(period / 2) is treated as floor(period / 2).
- R8: A period input below 4 is treated as 4 cycles.
- R9: Drive selection, on-time, dead-time and period are taken up only at the end of a period. A change made during a period leaves the rest of that period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_sel_i | input | 2 | Drive selection: 01 side A switches, 10 side B switches, 00/11 both legs off |
| period_i | input | 16 | Period length in clock cycles |
| hs_on_i | input | 16 | High-side conduction time per period, in cycles |
| dead_i | input | 16 | Dead interval length, in cycles |
| pwm_ah_o | output | 1 | Side A high-side gate (active low) |
| pwm_al_o | output | 1 | Side A low-side gate (active high) |
| pwm_bh_o | output | 1 | Side B high-side gate (active low) |
| pwm_bl_o | output | 1 | Side B low-side gate (active high) |

## Verification
The assertions check on every cycle that neither leg conducts through both of its switches at once, that the non-switching leg holds ground or both legs are off as the active selection requires, that the active setting changes only at a counter wrap, and that the counter stays within a period of at least four cycles. The exact number of cycles each gate spends high within a period, the dead-interval totals, the effect of each clamp, and the way a mid-period change is deferred to the following period can be shown only by the bench's scenarios, which count the cycles of complete periods.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

  localparam int CNT_W = 16;
  localparam int EXT_W = CNT_W + 1;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [EXT_W-1:0] ext_t;

  localparam cnt_t MIN_PERIOD = cnt_t'(4);

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_DRV_A = 2'b01,
    MODE_DRV_B = 2'b10,
    MODE_OFF   = 2'b11
  } drv_mode_e;

  typedef enum logic [1:0] {
    PH_HS_ON = 2'd0,
    PH_GAP   = 2'd1,
    PH_LS_ON = 2'd2
  } leg_phase_e;

  typedef struct packed {
    drv_mode_e mode;
    cnt_t      period;
    cnt_t      on_t;
    cnt_t      dead;
  } pwm_cfg_t;

  // Period floor.
  function automatic cnt_t fit_period(cnt_t p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

  // Dead interval may not exceed half the period.
  function automatic cnt_t fit_dead(cnt_t d, cnt_t p);
    cnt_t half;
    half = p >> 1;
    return (d > half) ? half : d;
  endfunction

  // On-time plus two dead intervals must fit the period (d <= p/2 assumed).
  function automatic cnt_t fit_on(cnt_t t, cnt_t d, cnt_t p);
    cnt_t room;
    room = p - (d << 1);
    return (t > room) ? room : t;
  endfunction

  // Position within the period -> phase of the switching leg.
  function automatic leg_phase_e phase_of(cnt_t c, cnt_t t, cnt_t d, cnt_t p);
    ext_t c_x;
    ext_t ls_beg;
    ext_t ls_end;
    c_x    = {1'b0, c};
    ls_beg = {1'b0, t} + {1'b0, d};
    ls_end = {1'b0, p} - {1'b0, d};
    if (c_x < {1'b0, t})   return PH_HS_ON;
    else if (c_x < ls_beg) return PH_GAP;
    else if (c_x < ls_end) return PH_LS_ON;
    else                   return PH_GAP;
  endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import hbpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t period,
  output cnt_t cnt_o,
  output logic wrap_o
);

  cnt_t cnt_q;

  assign wrap_o = (cnt_q == (period - cnt_t'(1)));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + cnt_t'(1);
  end

endmodule

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
  import hbpwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic [1:0] mode_raw,
  input  cnt_t     period_raw,
  input  cnt_t     on_raw,
  input  cnt_t     dead_raw,
  output pwm_cfg_t act_o
);

  pwm_cfg_t nxt;
  pwm_cfg_t act_q;

  always_comb begin
    nxt.mode   = drv_mode_e'(mode_raw);
    nxt.period = fit_period(period_raw);
    nxt.dead   = fit_dead(dead_raw, nxt.period);
    nxt.on_t   = fit_on(on_raw, nxt.dead, nxt.period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q.mode   <= MODE_IDLE;
      act_q.period <= MIN_PERIOD;
      act_q.on_t   <= '0;
      act_q.dead   <= '0;
    end else if (load) begin
      act_q <= nxt;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/pwm_leg_gen.sv
module pwm_leg_gen
  import hbpwm_pkg::*;
#(
  parameter bit LEG_IS_B = 1'b0
)(
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_cfg_t cfg,
  input  cnt_t     cnt,
  output logic     hs_n_o,
  output logic     ls_o
);

  localparam drv_mode_e OWN_MODE   = LEG_IS_B ? MODE_DRV_B : MODE_DRV_A;
  localparam drv_mode_e OTHER_MODE = LEG_IS_B ? MODE_DRV_A : MODE_DRV_B;

  leg_phase_e ph;
  logic       hs_n_d;
  logic       ls_d;
  logic       hs_n_q;
  logic       ls_q;

  always_comb ph = phase_of(cnt, cfg.on_t, cfg.dead, cfg.period);

  always_comb begin
    hs_n_d = 1'b1;
    ls_d   = 1'b0;
    if (cfg.mode == OWN_MODE) begin
      hs_n_d = (ph != PH_HS_ON);
      ls_d   = (ph == PH_LS_ON);
    end else if (cfg.mode == OTHER_MODE) begin
      hs_n_d = 1'b1;
      ls_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_n_q <= 1'b1;
      ls_q   <= 1'b0;
    end else begin
      hs_n_q <= hs_n_d;
      ls_q   <= ls_d;
    end
  end

  assign hs_n_o = hs_n_q;
  assign ls_o   = ls_q;

endmodule

// File: rtl/hbridge_pwm_drv.sv
module hbridge_pwm_drv
  import hbpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  drv_sel_i,
  input  logic [15:0] period_i,
  input  logic [15:0] hs_on_i,
  input  logic [15:0] dead_i,
  output logic        pwm_ah_o,
  output logic        pwm_al_o,
  output logic        pwm_bh_o,
  output logic        pwm_bl_o
);

  localparam int NUM_LEGS = 2;

  // Named internal events for the checker.
  logic     wrap_w;
  cnt_t     cnt_w;
  pwm_cfg_t act_cfg_w;

  logic [NUM_LEGS-1:0] leg_hs_n;
  logic [NUM_LEGS-1:0] leg_ls;

  pwm_period_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (act_cfg_w.period),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  pwm_cfg_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wrap_w),
    .mode_raw   (drv_sel_i),
    .period_raw (period_i),
    .on_raw     (hs_on_i),
    .dead_raw   (dead_i),
    .act_o      (act_cfg_w)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pwm_leg_gen #(.LEG_IS_B(g == 1)) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg    (act_cfg_w),
      .cnt    (cnt_w),
      .hs_n_o (leg_hs_n[g]),
      .ls_o   (leg_ls[g])
    );
  end

  assign pwm_ah_o = leg_hs_n[0];
  assign pwm_al_o = leg_ls[0];
  assign pwm_bh_o = leg_hs_n[1];
  assign pwm_bl_o = leg_ls[1];

endmodule

// File: rtl/hbpwm_checks.sv
module hbpwm_checks
  import hbpwm_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ah,
  input logic     al,
  input logic     bh,
  input logic     bl,
  input pwm_cfg_t cfg,
  input cnt_t     cnt,
  input logic     wrap
);

  p_no_shoot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ah && al) && !(!bh && bl));

  p_hold_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_DRV_A) |=> (bh && bl));

  p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_DRV_B) |=> (ah && al));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_IDLE || cfg.mode == MODE_OFF) |=> (ah && !al && bh && !bl));

  p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cfg));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.period >= MIN_PERIOD) && (cnt < cfg.period));

endmodule

bind hbridge_pwm_drv hbpwm_checks u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ah    (pwm_ah_o),
  .al    (pwm_al_o),
  .bh    (pwm_bh_o),
  .bl    (pwm_bl_o),
  .cfg   (act_cfg_w),
  .cnt   (cnt_w),
  .wrap  (wrap_w)
);

// File: tb/hbridge_pwm_drv_tb_top.sv
`timescale 1ns/1ps
module hbridge_pwm_drv_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  drv_sel = 2'b00;
  logic [15:0] period = 16'd20;
  logic [15:0] hs_on = 16'd0;
  logic [15:0] dead = 16'd0;
  logic        ah, al, bh, bl;

  int n_chk = 0;
  int n_fail = 0;
  // window counters
  int c_ah, c_al, c_bh, c_bl, c_ovl, c_gap_a, c_gap_b;

  always #2.5 clk = ~clk;

  hbridge_pwm_drv dut_i (
    .clk(clk), .rst_n(rst_n), .drv_sel_i(drv_sel), .period_i(period),
    .hs_on_i(hs_on), .dead_i(dead),
    .pwm_ah_o(ah), .pwm_al_o(al), .pwm_bh_o(bh), .pwm_bl_o(bl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input int p, input int t, input int d);
    @(negedge clk);
    drv_sel = m; period = 16'(p); hs_on = 16'(t); dead = 16'(d);
    repeat (60) @(negedge clk);
  endtask

  // Sample n consecutive cycles; first sample is the current negedge.
  task automatic window(input int n);
    c_ah = 0; c_al = 0; c_bh = 0; c_bl = 0; c_ovl = 0; c_gap_a = 0; c_gap_b = 0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      c_ah += int'(ah); c_al += int'(al); c_bh += int'(bh); c_bl += int'(bl);
      if ((!ah && al) || (!bh && bl)) c_ovl++;
      if (ah && !al) c_gap_a++;
      if (bh && !bl) c_gap_b++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ah in reset", int'(ah), 1);
    chk("R1", "al in reset", int'(al), 0);
    chk("R1", "bh in reset", int'(bh), 1);
    chk("R1", "bl in reset", int'(bl), 0);
    drv_sel = 2'b01; period = 16'd20; hs_on = 16'd8; dead = 16'd2;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ah after release", int'(ah), 1);
    chk("R1", "al after release", int'(al), 0);
  endtask

  task automatic t_drive_a();
    apply(2'b01, 20, 8, 2);
    window(20);
    chk("R2", "A high-side off cycles", c_ah, 12);
    chk("R2", "A low-side on cycles", c_al, 8);
    chk("R2", "B high held off", c_bh, 20);
    chk("R2", "B low held on", c_bl, 20);
    chk("R5", "overlap A", c_ovl, 0);
    chk("R5", "gap A", c_gap_a, 4);
  endtask

  task automatic t_drive_b();
    apply(2'b10, 20, 5, 1);
    window(20);
    chk("R3", "B high-side off cycles", c_bh, 15);
    chk("R3", "B low-side on cycles", c_bl, 13);
    chk("R3", "A high held off", c_ah, 20);
    chk("R3", "A low held on", c_al, 20);
    chk("R5", "overlap B", c_ovl, 0);
    chk("R5", "gap B", c_gap_b, 2);
  endtask

  task automatic t_idle();
    apply(2'b00, 20, 8, 2);
    window(20);
    chk("R4", "idle00 ah", c_ah, 20);
    chk("R4", "idle00 al", c_al, 0);
    chk("R4", "idle00 bh", c_bh, 20);
    chk("R4", "idle00 bl", c_bl, 0);
    apply(2'b11, 20, 8, 2);
    window(20);
    chk("R4", "idle11 ah", c_ah, 20);
    chk("R4", "idle11 al", c_al, 0);
    chk("R4", "idle11 bh", c_bh, 20);
    chk("R4", "idle11 bl", c_bl, 0);
  endtask

  task automatic t_clamp_on();
    apply(2'b01, 20, 50, 3);
    window(20);
    chk("R6", "clamped on: ah high", c_ah, 6);
    chk("R6", "clamped on: al high", c_al, 0);
    chk("R6", "clamped on: gap", c_gap_a, 6);
    chk("R5", "clamped on: overlap", c_ovl, 0);
  endtask

  task automatic t_clamp_dead();
    apply(2'b10, 20, 4, 15);
    window(20);
    chk("R7", "clamped dead: bh high", c_bh, 20);
    chk("R7", "clamped dead: bl high", c_bl, 0);
    chk("R7", "clamped dead: gap", c_gap_b, 20);
    apply(2'b01, 20, 0, 0);
    window(20);
    chk("R2", "zero on, zero dead: al high", c_al, 20);
    chk("R2", "zero on, zero dead: ah high", c_ah, 20);
  endtask

  task automatic t_min_period();
    apply(2'b01, 1, 1, 1);
    window(4);
    chk("R8", "short period: ah high", c_ah, 3);
    chk("R8", "short period: al high", c_al, 1);
    chk("R8", "short period: gap", c_gap_a, 2);
    window(4);
    chk("R8", "short period repeat: ah high", c_ah, 3);
  endtask

  task automatic t_boundary();
    logic prev;
    int   k;
    apply(2'b01, 20, 8, 2);
    prev = ah;
    k = 0;
    // find start of high-side conduction
    do begin
      @(negedge clk);
      k++;
      if (prev && !ah) break;
      prev = ah;
    end while (k < 100);
    chk("R9", "period start found", int'(k < 100), 1);
    hs_on = 16'd12;
    drv_sel = 2'b10;
    window(20);
    chk("R9", "old period ah high", c_ah, 12);
    chk("R9", "old period bl held", c_bl, 20);
    @(negedge clk);
    window(20);
    chk("R9", "new period bh high", c_bh, 8);
    chk("R9", "new period al held", c_al, 20);
  endtask

  initial begin
    t_reset();
    t_drive_a();
    t_drive_b();
    t_idle();
    t_clamp_on();
    t_clamp_dead();
    t_min_period();
    t_boundary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule